// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This unit corrects byte addresses of tiled surfaces for a dual-channel memory system whose channel select hashes several address bits into bit 6. A configuration word describing how memory is interleaved is captured on a load strobe. The unit decodes it into a swizzle mode and shows that mode on a 3-bit code. Every address presented with a tiling mode then leaves the unit at once, with bit 6 flipped by the parity of the bits that the mode and the tiling select. All other bits pass through unchanged.

A second path repairs whole 128-byte blocks of a page whose physical bit 17 has changed since its contents were written. Each block arrives with the bit 17 recorded when the page was last saved and the bit 17 of its current frame. When the two differ, the two 64-byte halves of the block are exchanged. When they match, the block passes through untouched. The path takes one block per cycle behind a valid/ready handshake and has a single output register.

Top module: `swz_unit`

## Requirements
- R1: With tiling code 0 (linear) or 3 (reserved), `addr_out` equals `addr_in` in every mode.
- R2: In mode code 1 (basic), X tiling (code 1) flips bit 6 by bit9^bit10 and Y tiling (code 2) flips it by bit9; no bit other than bit 6 ever differs between `addr_in` and `addr_out`.
- R3: In mode code 2, X tiling flips bit 6 by bit9^bit10^bit11 and Y tiling flips it by bit9^bit11.
- R4: In mode code 3, X tiling flips bit 6 by bit9^bit10^bit17 and Y tiling flips it by bit9^bit17.
- R5: A configuration with channel field `cfg_word[1:0]` = 0 (single channel) or 1 (dual, asymmetric) decodes to mode code 0, and mode 0 leaves every address unchanged.
- R6: With channel field 2 (dual interleaved), `cfg_word[2]` = 1 (channel hash off) decodes to code 1. Otherwise `cfg_word[3]` picks code 3 when set and code 2 when clear.
- R7: Channel field 3 (unknown layout) decodes to code 0 and sets `pin_pages`. Every other configuration clears `pin_pages`.
- R8: Code and `pin_pages` change only on the clock edge after `cfg_load` is high, and hold otherwise. After reset the code is 0 and `pin_pages` is 0.
- R9: An accepted block whose saved and current bit 17 differ comes out with byte i taken from input byte i^64 (byte 0 at bits [7:0]). When the two bits match, the block comes out unchanged.
- R10: A block accepted on a clock edge is presented with `blk_out_valid` high from the next cycle. While `blk_out_ready` is low, the block and its valid flag hold, and `blk_in_ready` is low.
- R11: After reset, `blk_out_valid` is 0 and `blk_in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture `cfg_word` into the mode register |
| cfg_word | input | 4 | [1:0] channel layout, [2] channel hash off, [3] bit-17 hash select |
| mode_code | output | 3 | Active swizzle mode: 0 none, 1 basic, 2 with bit 11, 3 with bit 17 |
| pin_pages | output | 1 | Layout unknown; pages must not move |
| tile_mode | input | 2 | 0 linear, 1 X, 2 Y, 3 reserved (treated as linear) |
| addr_in | input | 32 | Byte address before swizzle |
| addr_out | output | 32 | Byte address after swizzle |
| blk_in_valid | input | 1 | Input block valid |
| blk_in_ready | output | 1 | Input block can be taken |
| blk_in_data | input | 1024 | 128-byte input block, byte 0 in bits [7:0] |
| blk_saved_b17 | input | 1 | Bit 17 recorded for the page |
| blk_cur_b17 | input | 1 | Bit 17 of the current page frame |
| blk_out_valid | output | 1 | Output block valid |
| blk_out_ready | input | 1 | Output block accepted |
| blk_out_data | output | 1024 | 128-byte output block |

## Verification
The hardest situation to reach is an address whose swizzle terms cancel: bit 6 must stay put in a swizzling mode even though several of its hash bits are set. Random addresses seldom reach this together with each mode and each tiling. The stimulus therefore loads every one of the 16 configuration words and, for each of the four resulting modes, walks all 32 combinations of bits 6, 9, 10, 11 and 17 under all four tiling codes. The block path is held under backpressure for an extra cycle, so the hold behaviour is exercised with both the swapping and the pass-through case.

// File: rtl/swz_pkg.sv
// Shared types for the swizzle unit: tiling codes, mode codes, config layout.
package swz_pkg;
    localparam int CFG_W  = 4;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        TILE_LIN = 2'd0,
        TILE_X   = 2'd1,
        TILE_Y   = 2'd2,
        TILE_RSV = 2'd3
    } tile_e;

    typedef enum logic [CODE_W-1:0] {
        SWZ_NONE  = 3'd0,
        SWZ_BASIC = 3'd1,
        SWZ_B11   = 3'd2,
        SWZ_B17   = 3'd3
    } swz_mode_e;

    typedef enum logic [1:0] {
        CH_SINGLE = 2'd0,
        CH_ASYM   = 2'd1,
        CH_INTLV  = 2'd2,
        CH_UNK    = 2'd3
    } chan_e;
endpackage

// File: rtl/swz_mode_sel.sv
// Decodes the memory interleave configuration into a swizzle mode and holds
// it in a register loaded by a strobe.
// Assumes: cfg_word is stable in the cycle cfg_load is high.
module swz_mode_sel
    import swz_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg,
    output swz_mode_e        mode,
    output logic             pin
);
    swz_mode_e dec_mode;
    logic      dec_unk;
    chan_e     chan;

    assign chan = chan_e'(cfg[1:0]);

    // Map the channel layout and hash bits to a mode code.
    always_comb begin
        dec_mode = SWZ_NONE;
        dec_unk  = 1'b0;
        case (chan)
            CH_SINGLE, CH_ASYM: dec_mode = SWZ_NONE;
            CH_INTLV: begin
                if (cfg[2])      dec_mode = SWZ_BASIC;
                else if (cfg[3]) dec_mode = SWZ_B17;
                else             dec_mode = SWZ_B11;
            end
            default: begin
                dec_mode = SWZ_NONE;
                dec_unk  = 1'b1;
            end
        endcase
    end

    // Mode register, updated only on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= SWZ_NONE;
            pin  <= 1'b0;
        end else if (load) begin
            mode <= dec_mode;
            pin  <= dec_unk;
        end
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode) && $stable(pin));
    // R7
    pin_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin |-> mode == SWZ_NONE);
endmodule

// File: rtl/swz_addr.sv
// Combinational bit-6 swizzle of one byte address.
// Assumes: ADDR_W > 17 so that every hash bit exists.
module swz_addr
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  swz_mode_e         mode,
    input  tile_e             tile,
    input  logic [ADDR_W-1:0] a_in,
    output logic [ADDR_W-1:0] a_out
);
    localparam int SWZ_BIT = 6;

    logic is_x, is_y, base, extra, flip;

    // Gather the hash terms chosen by tiling and mode.
    always_comb begin
        is_x  = (tile == TILE_X);
        is_y  = (tile == TILE_Y);
        base  = a_in[9] ^ (is_x & a_in[10]);
        case (mode)
            SWZ_B11: extra = a_in[11];
            SWZ_B17: extra = a_in[17];
            default: extra = 1'b0;
        endcase
        flip  = (mode != SWZ_NONE) & (is_x | is_y) & (base ^ extra);
    end

    // Apply the flip to bit 6 only.
    always_comb begin
        a_out          = a_in;
        a_out[SWZ_BIT] = a_in[SWZ_BIT] ^ flip;
    end
endmodule

// File: rtl/swz_fixup.sv
// Bit-17 page fix-up: swaps the 64-byte halves of a block when the saved and
// current bit 17 differ. One output register, valid/ready on both sides.
// Assumes: BLOCK_BYTES is even.
module swz_fixup #(
    parameter int BLOCK_BYTES = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [BLOCK_BYTES*8-1:0] in_data,
    input  logic                     saved_b17,
    input  logic                     cur_b17,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [BLOCK_BYTES*8-1:0] out_data
);
    localparam int HALF = BLOCK_BYTES / 2;
    localparam int DW   = BLOCK_BYTES * 8;

    logic          do_swap;
    logic [DW-1:0] swapped;
    logic          take;

    assign do_swap  = saved_b17 ^ cur_b17;
    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // Byte i of the swapped block comes from byte i^HALF.
    for (genvar i = 0; i < BLOCK_BYTES; i++) begin : g_byte
        assign swapped[i*8 +: 8] = in_data[(i ^ HALF)*8 +: 8];
    end

    // Output register: load on accept, clear valid when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= do_swap ? swapped : in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
    // R9
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !do_swap |=> out_data == $past(in_data));
endmodule

// File: rtl/swz_unit.sv
// Top of the bit-6 swizzle unit: mode register, address swizzle and the
// bit-17 block fix-up path.
// Assumes: synchronous active-low reset; address path is combinational.
module swz_unit
    import swz_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_load,
    input  logic [3:0]               cfg_word,
    output logic [2:0]               mode_code,
    output logic                     pin_pages,
    input  logic [1:0]               tile_mode,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-1:0]        addr_out,
    input  logic                     blk_in_valid,
    output logic                     blk_in_ready,
    input  logic [BLOCK_BYTES*8-1:0] blk_in_data,
    input  logic                     blk_saved_b17,
    input  logic                     blk_cur_b17,
    output logic                     blk_out_valid,
    input  logic                     blk_out_ready,
    output logic [BLOCK_BYTES*8-1:0] blk_out_data
);
    swz_mode_e mode;

    // Mode decode and register.
    swz_mode_sel u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .cfg   (cfg_word),
        .mode  (mode),
        .pin   (pin_pages)
    );

    assign mode_code = mode;

    // Address swizzle.
    swz_addr #(.ADDR_W(ADDR_W)) u_addr (
        .mode  (mode),
        .tile  (tile_e'(tile_mode)),
        .a_in  (addr_in),
        .a_out (addr_out)
    );

    // Block fix-up path.
    swz_fixup #(.BLOCK_BYTES(BLOCK_BYTES)) u_fix (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (blk_in_valid),
        .in_ready  (blk_in_ready),
        .in_data   (blk_in_data),
        .saved_b17 (blk_saved_b17),
        .cur_b17   (blk_cur_b17),
        .out_valid (blk_out_valid),
        .out_ready (blk_out_ready),
        .out_data  (blk_out_data)
    );

    // R1
    linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_mode == 2'd0 || tile_mode == 2'd3) |-> addr_out == addr_in);
    // R2
    only_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_out ^ addr_in) & ~(ADDR_W'(1) << 6)) == '0);
    // R5
    none_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code == 3'd0 |-> addr_out == addr_in);
endmodule

// File: tb/sim_swz_unit.sv
module sim_swz_unit;
    localparam int AW = 32;
    localparam int BB = 128;
    localparam int DW = BB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [3:0]    cfg_word = '0;
    logic [2:0]    mode_code;
    logic          pin_pages;
    logic [1:0]    tile_mode = '0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          blk_in_valid = 1'b0;
    logic          blk_in_ready;
    logic [DW-1:0] blk_in_data = '0;
    logic          blk_saved_b17 = 1'b0;
    logic          blk_cur_b17 = 1'b0;
    logic          blk_out_valid;
    logic          blk_out_ready = 1'b0;
    logic [DW-1:0] blk_out_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    swz_unit u0 (.*);

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_code(input logic [3:0] c);
        case (c[1:0])
            2'd2:    exp_code = c[2] ? 3'd1 : (c[3] ? 3'd3 : 3'd2);
            default: exp_code = 3'd0;
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a,
                                               input logic [2:0] m,
                                               input logic [1:0] t);
        logic f;
        f = 1'b0;
        if (m != 3'd0 && (t == 2'd1 || t == 2'd2)) begin
            f = a[9];
            if (t == 2'd1) f = f ^ a[10];
            if (m == 3'd2) f = f ^ a[11];
            if (m == 3'd3) f = f ^ a[17];
        end
        exp_addr = a ^ (AW'(f) << 6);
    endfunction

    function automatic logic [DW-1:0] pattern(input int seed);
        logic [DW-1:0] d;
        for (int i = 0; i < BB; i++) d[i*8 +: 8] = 8'((i * 7 + seed * 13) & 255);
        return d;
    endfunction

    function automatic logic [DW-1:0] swap_halves(input logic [DW-1:0] d);
        logic [DW-1:0] r;
        for (int i = 0; i < BB; i++) r[i*8 +: 8] = d[(i ^ 64)*8 +: 8];
        return r;
    endfunction

    task automatic load_cfg(input logic [3:0] c);
        @(negedge clk);
        cfg_word = c;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] a;
        logic [DW-1:0] d, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 R11 reset state
        chk(mode_code == 3'd0, "R8 reset code", DW'(mode_code), 0);
        chk(pin_pages == 1'b0, "R8 reset pin", DW'(pin_pages), 0);
        chk(blk_out_valid == 1'b0, "R11 reset out_valid", DW'(blk_out_valid), 0);
        chk(blk_in_ready == 1'b1, "R11 reset in_ready", DW'(blk_in_ready), 1);

        // R5 R6 R7 every configuration word
        for (int c = 0; c < 16; c++) begin
            load_cfg(4'(c));
            chk(mode_code == exp_code(4'(c)), "R6 R5 decode", DW'(mode_code),
                DW'(exp_code(4'(c))));
            chk(pin_pages == (c[1:0] == 2'd3), "R7 pin flag", DW'(pin_pages),
                DW'(c[1:0] == 2'd3));
        end

        // R8 no change without load
        load_cfg(4'b0110);
        @(negedge clk);
        cfg_word = 4'b0011;
        repeat (2) @(negedge clk);
        chk(mode_code == 3'd1 && !pin_pages, "R8 hold without load",
            DW'(mode_code), 1);

        // R1 R2 R3 R4 R5 sweep per mode
        for (int m = 0; m < 4; m++) begin
            case (m)
                0: load_cfg(4'b0000);
                1: load_cfg(4'b0110);
                2: load_cfg(4'b0010);
                default: load_cfg(4'b1010);
            endcase
            for (int t = 0; t < 4; t++) begin
                for (int k = 0; k < 32; k++) begin
                    a = 32'h5A3C_8135 & ~32'h0002_0E40;
                    a[6] = k[0]; a[9] = k[1]; a[10] = k[2]; a[11] = k[3]; a[17] = k[4];
                    a = a ^ AW'((k * 32'h0104_0000) & 32'hFFFC_0000);
                    tile_mode = 2'(t);
                    addr_in = a;
                    #1;
                    case (m)
                        0: chk(addr_out == exp_addr(a, 3'(m), 2'(t)), "R5 none", DW'(addr_out), DW'(exp_addr(a, 3'(m), 2'(t))));
                        1: chk(addr_out == exp_addr(a, 3'(m), 2'(t)), "R2 R1 basic", DW'(addr_out), DW'(exp_addr(a, 3'(m), 2'(t))));
                        2: chk(addr_out == exp_addr(a, 3'(m), 2'(t)), "R3 R1 bit11", DW'(addr_out), DW'(exp_addr(a, 3'(m), 2'(t))));
                        default: chk(addr_out == exp_addr(a, 3'(m), 2'(t)), "R4 R1 bit17", DW'(addr_out), DW'(exp_addr(a, 3'(m), 2'(t))));
                    endcase
                end
            end
        end

        // R9 R10 block path, all four bit-17 combinations, with backpressure
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            d = pattern(s + 1);
            e = (s[0] ^ s[1]) ? swap_halves(d) : d;
            blk_in_data = d;
            blk_saved_b17 = s[0];
            blk_cur_b17 = s[1];
            blk_in_valid = 1'b1;
            blk_out_ready = 1'b0;
            @(negedge clk);
            blk_in_valid = 1'b0;
            blk_in_data = pattern(s + 9);
            chk(blk_out_valid == 1'b1, "R10 valid after accept", DW'(blk_out_valid), 1);
            chk(blk_out_data == e, "R9 block data", blk_out_data, e);
            chk(blk_in_ready == 1'b0, "R10 in_ready low under stall", DW'(blk_in_ready), 0);
            @(negedge clk);
            chk(blk_out_valid == 1'b1 && blk_out_data == e, "R10 hold under stall",
                blk_out_data, e);
            blk_out_ready = 1'b1;
            @(negedge clk);
            chk(blk_out_valid == 1'b0, "R10 drained", DW'(blk_out_valid), 0);
        end

        // R10 back-to-back blocks, one per cycle
        @(negedge clk);
        blk_out_ready = 1'b1;
        blk_saved_b17 = 1'b1;
        blk_cur_b17 = 1'b0;
        blk_in_valid = 1'b1;
        blk_in_data = pattern(20);
        @(negedge clk);
        chk(blk_out_data == swap_halves(pattern(20)), "R9 stream first",
            blk_out_data, swap_halves(pattern(20)));
        blk_in_data = pattern(21);
        blk_cur_b17 = 1'b1;
        @(negedge clk);
        blk_in_valid = 1'b0;
        chk(blk_out_valid && blk_out_data == pattern(21), "R10 stream second",
            blk_out_data, pattern(21));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule